// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the software-visible face of a 16550-style serial port without FIFOs. A simple 32-bit word bus reads and writes eight registers on a four-byte stride. Received bytes come in on a byte stream and are parked in a single holding register. Bytes written by software leave on a transmit byte stream. One interrupt line, together with an identification code, tells software which condition needs attention first.

The bit-level serial engine, baud generation and modem pin sampling live elsewhere. This block keeps the line control, modem control and divisor values and drives them out to that logic. It takes receive error flags with each byte. It takes a modem status byte, which it registers every cycle.

Two small state machines carry the behaviour. The receive holder has the states RX_EMPTY and RX_FULL:
- A byte arriving in either state moves it to RX_FULL.
- RX_FULL returns to RX_EMPTY only on a data-register read that has no byte arriving in the same cycle.

The transmit holder has the states TX_IDLE and TX_HOLD:
- A data-register write moves TX_IDLE to TX_HOLD.
- TX_HOLD returns to TX_IDLE when the sink accepts the byte.

Top module: `uart_regfront`

## Requirements
- R1: After reset the line status register reads 0x60 and the identification register reads 0x1. The interrupt is low, `rx_ready` is high, `tx_valid` is low, and the control outputs are zero. The error and overrun flags are cleared.
- R2: The register index is `bus_addr >> 2`. The registers are: 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. Indices 1, 3, 4 and 7 are writable and always read as zero. The stored line control, modem control and divisor values appear on `line_ctrl`, `modem_ctrl` and `divisor`.
- R3: Writes to indices 2, 5 and 6, and any access at index 8 or above, change no state.
- R4: A byte presented with `rx_valid` is captured in any cycle. It sets data ready (line status bit 0). `rx_ready` is high exactly while data ready is clear.
- R5: A byte arriving while data ready is set sets overrun (line status bit 1) and replaces the held byte. Overrun stays set until reset.
- R6: A read of index 0 returns the held byte in bits 7:0 and clears data ready. If a new byte arrives in the same cycle, data ready stays set and no overrun is flagged.
- R7: The `rx_err` flags are parity (bit 0), framing (bit 1) and break (bit 2). When they accompany a byte, they set line status bits 2, 3 and 4. These bits stay set until reset.
- R8: A write to index 0 while the transmit holder is idle presents `bus_wdata[7:0]` on `tx_data` with `tx_valid` high. Both hold until `tx_ready` is sampled high. Line status bits 5 and 6 are clear while a byte is pending.
- R9: A write to index 0 while a transmit byte is pending is dropped.
- R10: The interrupt enable bits are: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status. Identification codes by priority, highest first:
  - 0b110: any of line status bits 1..4, with bit 2 enabled.
  - 0b100: data ready, with bit 0 enabled.
  - 0b010: transmit empty, with bit 1 enabled.
  - 0b000: any of modem status bits 3..0, with bit 3 enabled.
  - 0b001: none of the above, and the interrupt is low.
- R11: The interrupt and identification follow the register contents combinationally, in the same cycle the state changes.
- R12: `modem_stat` is registered every cycle and read back at index 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, word index in bits above 1:0 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle, zero otherwise |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Error flags with the byte: parity, framing, break |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Holding register empty |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Sink accepts the byte |
| modem_stat | input | 8 | Modem status from pin logic, deltas in bits 3:0 |
| line_ctrl | output | LCR_W | Stored line control value |
| modem_ctrl | output | MCR_W | Stored modem control value |
| divisor | output | DIV_W | Stored divisor value |
| irq | output | 1 | Interrupt request |

## Verification
The bench feeds two bytes without a read in between. A design that skips overrun would report 0x61 instead of 0x63. Overrun and error flags are read back after the data read to expose logic that wrongly clears them. A data read that coincides with a new byte checks that data ready survives and no spurious overrun appears; a naive design would drop the second byte's ready flag. Priority is tested with several sources active at once: line status over data ready, and transmit empty over modem status. A second transmit write while one byte is pending must not replace the byte on the stream.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

    localparam int IDX_DATA = 0;
    localparam int IDX_IER  = 1;
    localparam int IDX_IID  = 2;
    localparam int IDX_LCR  = 3;
    localparam int IDX_MCR  = 4;
    localparam int IDX_LSR  = 5;
    localparam int IDX_MSR  = 6;
    localparam int IDX_DIV  = 7;
    localparam int NUM_REGS = 8;

    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;
    localparam int IER_W  = 4;

    localparam logic [2:0] IID_LINE  = 3'b110;
    localparam logic [2:0] IID_RXD   = 3'b100;
    localparam logic [2:0] IID_TXE   = 3'b010;
    localparam logic [2:0] IID_MODEM = 3'b000;
    localparam logic [2:0] IID_NONE  = 3'b001;

    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_e;
    typedef enum logic {TX_IDLE, TX_HOLD} tx_state_e;

    typedef struct packed {
        logic temt;
        logic thre;
        logic brk;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } lsr_t;

endpackage

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold
    import uart_regfront_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic [2:0] rx_err,
    input  logic       rx_valid,
    input  logic       rd_pulse,
    output logic [7:0] hold_byte,
    output logic       dr,
    output logic       oe,
    output logic [2:0] err_flags,
    output logic       rx_ready
);

    rx_state_e state_q, state_d;
    logic [7:0] byte_q;
    logic       oe_q;
    logic [2:0] err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (rx_valid) state_d = RX_FULL;
            RX_FULL: begin
                if (rx_valid)      state_d = RX_FULL;
                else if (rd_pulse) state_d = RX_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            oe_q   <= 1'b0;
            err_q  <= '0;
        end else if (rx_valid) begin
            byte_q <= rx_data;
            err_q  <= err_q | rx_err;
            if (state_q == RX_FULL && !rd_pulse) oe_q <= 1'b1;
        end
    end

    always_comb begin
        dr        = (state_q == RX_FULL);
        rx_ready  = (state_q == RX_EMPTY);
        hold_byte = byte_q;
        oe        = oe_q;
        err_flags = err_q;
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> dr);
    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> oe);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != 3'b000) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

endmodule

// File: rtl/uart_rf_txhold.sv
module uart_rf_txhold
    import uart_regfront_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_pulse,
    input  logic [7:0] wr_byte,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    output logic       tx_idle
);

    tx_state_e state_q, state_d;
    logic [7:0] byte_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (wr_pulse) state_d = TX_HOLD;
            TX_HOLD: if (tx_ready) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && wr_pulse) byte_q <= wr_byte;
        end
    end

    always_comb begin
        tx_valid = (state_q == TX_HOLD);
        tx_idle  = (state_q == TX_IDLE);
        tx_data  = byte_q;
    end

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    p_drop_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && wr_pulse) |=> $stable(tx_data));

endmodule

// File: rtl/uart_rf_irqenc.sv
module uart_rf_irqenc
    import uart_regfront_pkg::*;
(
    input  logic [IER_W-1:0] ier,
    input  lsr_t             lsr,
    input  logic [3:0]       msr_delta,
    output logic [2:0]       iid,
    output logic             irq
);

    logic line_evt, rx_evt, tx_evt, ms_evt;

    always_comb begin
        line_evt = (lsr.oe | lsr.pe | lsr.fe | lsr.brk) & ier[EN_LS];
        rx_evt   = lsr.dr & ier[EN_RX];
        tx_evt   = lsr.thre & ier[EN_TX];
        ms_evt   = (|msr_delta) & ier[EN_MS];
        irq      = 1'b1;
        if (line_evt)    iid = IID_LINE;
        else if (rx_evt) iid = IID_RXD;
        else if (tx_evt) iid = IID_TXE;
        else if (ms_evt) iid = IID_MODEM;
        else begin
            iid = IID_NONE;
            irq = 1'b0;
        end
    end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LCR_W  = 8,
    parameter int MCR_W  = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [7:0]        rx_data,
    input  logic [2:0]        rx_err,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        modem_stat,
    output logic [LCR_W-1:0]  line_ctrl,
    output logic [MCR_W-1:0]  modem_ctrl,
    output logic [DIV_W-1:0]  divisor,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_REGS-1:0] hit;
    logic [NUM_REGS-1:0] wr_hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign hit[g]    = (bus_addr[ADDR_W-1:2] == IDX_W'(g));
        assign wr_hit[g] = bus_we & hit[g];
    end

    logic rd_data_pulse;
    assign rd_data_pulse = bus_re & hit[IDX_DATA];

    logic [IER_W-1:0] ier_q;
    logic [LCR_W-1:0] lcr_q;
    logic [MCR_W-1:0] mcr_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       msr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
            lcr_q <= '0;
            mcr_q <= '0;
            div_q <= '0;
            msr_q <= '0;
        end else begin
            msr_q <= modem_stat;
            if (wr_hit[IDX_IER]) ier_q <= bus_wdata[IER_W-1:0];
            if (wr_hit[IDX_LCR]) lcr_q <= bus_wdata[LCR_W-1:0];
            if (wr_hit[IDX_MCR]) mcr_q <= bus_wdata[MCR_W-1:0];
            if (wr_hit[IDX_DIV]) div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    logic [7:0] hold_byte;
    logic       dr, oe, tx_idle;
    logic [2:0] err_flags;

    uart_rf_rxhold u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_err    (rx_err),
        .rx_valid  (rx_valid),
        .rd_pulse  (rd_data_pulse),
        .hold_byte (hold_byte),
        .dr        (dr),
        .oe        (oe),
        .err_flags (err_flags),
        .rx_ready  (rx_ready)
    );

    uart_rf_txhold u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (wr_hit[IDX_DATA]),
        .wr_byte  (bus_wdata[7:0]),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_idle  (tx_idle)
    );

    lsr_t lsr;
    always_comb begin
        lsr.dr   = dr;
        lsr.oe   = oe;
        lsr.pe   = err_flags[0];
        lsr.fe   = err_flags[1];
        lsr.brk  = err_flags[2];
        lsr.thre = tx_idle;
        lsr.temt = tx_idle;
    end

    logic [2:0] iid;

    uart_rf_irqenc u_irq (
        .ier       (ier_q),
        .lsr       (lsr),
        .msr_delta (msr_q[3:0]),
        .iid       (iid),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (hit[IDX_DATA]) bus_rdata[7:0] = hold_byte;
            if (hit[IDX_IID])  bus_rdata[2:0] = iid;
            if (hit[IDX_LSR])  bus_rdata[6:0] = lsr;
            if (hit[IDX_MSR])  bus_rdata[7:0] = msr_q;
        end
    end

    assign line_ctrl  = lcr_q;
    assign modem_ctrl = mcr_q;
    assign divisor    = div_q;

    logic unused_bits;
    assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

    p_wo_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (hit[IDX_IER] || hit[IDX_LCR] || hit[IDX_MCR] || hit[IDX_DIV]))
        |-> (bus_rdata == '0));
    p_ro_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !(|hit)) |=> ($stable(ier_q) && $stable(lcr_q) && $stable(div_q)));
    p_irq_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (iid[0] == 1'b0));
    p_idle_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iid == IID_NONE));
    p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_pulse && !rx_valid) |=> rx_ready);

endmodule

// File: tb/uart_regfront_tb_top.sv
`timescale 1ns/1ps
module uart_regfront_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic [2:0]  rx_err = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  modem_stat = '0;
    logic [7:0]  line_ctrl, modem_ctrl;
    logic [15:0] divisor;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uart_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_err(rx_err), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .modem_stat(modem_stat), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
        .divisor(divisor), .irq(irq)
    );

    // op(1: 1=read) addr(8) data(32) expected(8) irq(1)
    localparam int NV = 15;
    localparam logic [49:0] VEC [NV] = '{
        {1'b1, 8'h14, 32'h0,        8'h60, 1'b0},  // R1 reset LSR
        {1'b1, 8'h08, 32'h0,        8'h01, 1'b0},  // R1 reset IID
        {1'b0, 8'h04, 32'h2,        8'h00, 1'b1},  // R11 irq rises same cycle
        {1'b1, 8'h08, 32'h0,        8'h02, 1'b1},  // R10 tx-empty code
        {1'b1, 8'h04, 32'h0,        8'h00, 1'b1},  // R2 write-only reads zero
        {1'b0, 8'h14, 32'hFF,       8'h00, 1'b1},  // R3 LSR write
        {1'b1, 8'h14, 32'h0,        8'h60, 1'b1},  // R3 LSR unchanged
        {1'b0, 8'h08, 32'h0,        8'h00, 1'b1},  // R3 IID write
        {1'b1, 8'h08, 32'h0,        8'h02, 1'b1},  // R3 IID unchanged
        {1'b0, 8'h40, 32'hFFFFFFFF, 8'h00, 1'b1},  // R3 out-of-range write
        {1'b1, 8'h08, 32'h0,        8'h02, 1'b1},  // R3 enables unchanged
        {1'b0, 8'h04, 32'h0,        8'h00, 1'b0},  // R10 disable all
        {1'b1, 8'h08, 32'h0,        8'h01, 1'b0},  // R10 none code
        {1'b0, 8'h0C, 32'hAB,       8'h00, 1'b0},  // R2 line control write
        {1'b1, 8'h0C, 32'h0,        8'h00, 1'b0}   // R2 line control reads zero
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdc(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic [2:0] e);
        @(negedge clk);
        rx_data = b; rx_err = e; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_err = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 irq", irq, 0);
        chk("R1 rx_ready", rx_ready, 1);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 line_ctrl", line_ctrl, 0);
        chk("R1 divisor", divisor, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][49]) begin
                rdc($sformatf("vec%0d R2/R3/R10 rdata", i), VEC[i][48:41], {24'h0, VEC[i][8:1]});
            end else begin
                wr(VEC[i][48:41], VEC[i][40:9]);
            end
            chk($sformatf("vec%0d R11 irq", i), irq, VEC[i][0]);
        end

        chk("R2 line_ctrl out", line_ctrl, 32'hAB);
        wr(8'h1C, 32'h1234);
        wr(8'h10, 32'h3);
        rdc("R2 divisor reads zero", 8'h1C, 0);
        rdc("R2 modem ctrl reads zero", 8'h10, 0);
        chk("R2 divisor out", divisor, 32'h1234);
        chk("R2 modem_ctrl out", modem_ctrl, 3);

        // transmit
        wr(8'h00, 32'h1A5);
        chk("R8 tx_valid", tx_valid, 1);
        chk("R8 tx_data", tx_data, 32'hA5);
        rdc("R8 LSR busy", 8'h14, 32'h00);
        wr(8'h00, 32'h33);
        chk("R9 dropped write", tx_data, 32'hA5);
        repeat (3) @(negedge clk);
        chk("R8 held without ready", tx_valid, 1);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R8 released", tx_valid, 0);
        rdc("R8 LSR idle", 8'h14, 32'h60);

        // receive
        rx_send(8'h5A, 3'b000);
        chk("R4 rx_ready low", rx_ready, 0);
        rdc("R4 LSR dr", 8'h14, 32'h61);
        wr(8'h04, 32'h1);
        chk("R10 rx irq", irq, 1);
        rdc("R10 rx code", 8'h08, 32'h4);
        rdc("R6 data", 8'h00, 32'h5A);
        chk("R6 rx_ready back", rx_ready, 1);
        chk("R11 irq drops", irq, 0);
        rdc("R6 LSR cleared", 8'h14, 32'h60);

        // overrun
        rx_send(8'h11, 3'b000);
        rx_send(8'h22, 3'b000);
        rdc("R5 LSR overrun", 8'h14, 32'h63);
        rdc("R5 newest byte", 8'h00, 32'h22);
        rdc("R5 overrun sticky", 8'h14, 32'h62);
        wr(8'h04, 32'h5);
        rdc("R10 line code", 8'h08, 32'h6);
        rx_send(8'h33, 3'b000);
        rdc("R10 line over rx", 8'h08, 32'h6);
        rdc("R5 data", 8'h00, 32'h33);

        // error flags
        rx_send(8'h44, 3'b101);
        rdc("R7 LSR errors", 8'h14, 32'h77);
        rdc("R7 data", 8'h00, 32'h44);
        rdc("R7 errors sticky", 8'h14, 32'h76);

        do_reset();
        rdc("R1 reset clears flags", 8'h14, 32'h60);

        // read and receive in the same cycle
        rx_send(8'h55, 3'b000);
        @(negedge clk);
        bus_addr = 8'h00; bus_re = 1'b1;
        rx_data = 8'h66; rx_valid = 1'b1;
        #1 chk("R6 same-cycle old byte", bus_rdata, 32'h55);
        @(negedge clk);
        bus_re = 1'b0; rx_valid = 1'b0;
        rdc("R6 same-cycle no overrun", 8'h14, 32'h61);
        rdc("R6 same-cycle new byte", 8'h00, 32'h66);

        // modem status
        wr(8'h04, 32'h8);
        @(negedge clk);
        modem_stat = 8'h01;
        @(negedge clk);
        chk("R12 modem irq", irq, 1);
        rdc("R12 msr read", 8'h18, 32'h01);
        rdc("R10 modem code", 8'h08, 32'h0);
        modem_stat = 8'hF0;
        @(negedge clk);
        chk("R10 no delta no irq", irq, 0);
        rdc("R10 none code", 8'h08, 32'h1);
        modem_stat = 8'h02;
        wr(8'h04, 32'hA);
        rdc("R10 tx over modem", 8'h08, 32'h2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule